// File: doc/BRIEF.md
# Serial Register Command Decoder

This block is the serial-interface front end that handles the control-register commands of a serial memory. It watches an active-low chip select, a serial clock and a single serial data line. It collects each frame and acts on it when chip select returns high. Three things are kept here:

- a write-enable latch;
- an 8-bit volatile configuration register, written by a dedicated two-byte command;
- a two-step software reset sequence that sends a one-cycle reset pulse to the rest of the device.

The serial pins are oversampled by a fast system clock, and every action is taken on that clock. A command counts only if chip select rises exactly at the end of its frame. A register write needs the write-enable latch to be set, and the latch clears itself once the write is taken. The reset pulse needs a reset-enable command immediately before the reset command. The register reset value comes from a nonvolatile configuration input. The same value is reloaded on a software reset.

Top module: `flash_reg_cmd`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `cfgReg` equals `nvCfg`, `wel` is 0 and `softRst` is 0.
- R2: A frame of exactly 8 bits carrying opcode 0x06 sets `wel` to 1.
- R3: A frame of exactly 16 bits, opcode 0x61 followed by a data byte (both MSB first), received while `wel` is 1, loads the data byte into `cfgReg` and clears `wel`. Both changes are visible in the first system-clock cycle after chip select is sampled high.
- R4: A 0x61 frame received while `wel` is 0 leaves `cfgReg` and `wel` unchanged.
- R5: A 0x61 frame whose chip select rises after any bit count other than 16 leaves `cfgReg` and `wel` unchanged.
- R6: A 0x06 frame whose chip select rises after any bit count other than 8 leaves `wel` unchanged.
- R7: Opcode 0x66 in an exact 8-bit frame arms the reset. An exact 8-bit frame with opcode 0x99 that follows it has these effects: `softRst` is high for exactly one cycle, `cfgReg` takes the current `nvCfg`, and `wel` is cleared. Frames shorter than 8 bits in between do not disarm the reset.
- R8: An exact 8-bit 0x99 frame with no armed reset has no effect. Any frame of 8 or more bits other than an exact 8-bit 0x66 frame disarms the reset.
- R9: Frames whose opcode is none of 0x06, 0x61, 0x66 or 0x99 change neither `cfgReg` nor `wel`.
- R10: Serial clock edges while chip select is high shift no bits into the next frame.
- R11: Changes of `nvCfg` outside reset leave `cfgReg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Synchronous active-low hardware reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| mosi | input | 1 | Serial data in, MSB first |
| nvCfg | input | 8 | Nonvolatile default for the configuration register |
| cfgReg | output | 8 | Current volatile configuration register value |
| wel | output | 1 | Write-enable latch state |
| softRst | output | 1 | One-cycle software reset pulse for the rest of the device |

## Verification
Wrong internal state shows up at the ports in one of two ways. A miscounted bit counter or a dropped shift bit gives a register value or latch state that differs at the first accepted frame end. A stale reset arm shows up as a reset pulse that fires, or fails to fire, one cycle after the next reset-memory frame. Because every effect lands in the cycle after chip select is sampled high, a behavioural model in the bench can be compared with `cfgReg`, `wel` and `softRst` on every clock. Any divergence is then caught within one cycle of the frame that caused it.

// File: rtl/flash_reg_cmd_pkg.sv
package flash_reg_cmd_pkg;

  localparam logic [7:0] OP_WRITE_EN  = 8'h06;
  localparam logic [7:0] OP_WRITE_CFG = 8'h61;
  localparam logic [7:0] OP_RESET_ARM = 8'h66;
  localparam logic [7:0] OP_RESET_GO  = 8'h99;

  typedef struct packed {
    logic loadCfg;
    logic restoreCfg;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import flash_reg_cmd_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int DATA_BITS = 8,
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  sclk,
  input  logic                  mosi,
  input  logic [DATA_BITS-1:0]  nvCfg,
  input  dpStrobe_t             strobe,
  output logic                  csRise,
  output logic [CNT_W-1:0]      bitCnt,
  output logic [FRAME_BITS-1:0] shiftWord,
  output logic [DATA_BITS-1:0]  cfgReg
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

  logic sclkQ;
  logic csQ;
  logic sclkRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
    end
  end

  assign sclkRise = sclk & ~sclkQ & ~csN;
  assign csRise   = csN & ~csQ;

  // Frame collection: cleared while deselected, saturating count
  always_ff @(posedge clk) begin
    if (!rstN || csN) begin
      bitCnt    <= '0;
      shiftWord <= '0;
    end else if (sclkRise) begin
      shiftWord <= {shiftWord[FRAME_BITS-2:0], mosi};
      if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
    end
  end

  // Volatile configuration register
  always_ff @(posedge clk) begin
    if (!rstN || strobe.restoreCfg) cfgReg <= nvCfg;
    else if (strobe.loadCfg)        cfgReg <= shiftWord[DATA_BITS-1:0];
  end

  // R10: a serial edge while deselected never advances the count
  a_r10_idle_no_count: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && csN) |-> (bitCnt == '0));

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import flash_reg_cmd_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int DATA_BITS = 8,
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csRise,
  input  logic [CNT_W-1:0]      bitCnt,
  input  logic [FRAME_BITS-1:0] shiftWord,
  output dpStrobe_t             strobe,
  output logic                  wel,
  output logic                  softRst
);

  logic [CMD_BITS-1:0] opcode;
  logic endCmd, endWrite, anyCmd;
  logic doWren, doArm, doReset, doLoad;
  logic rstArmed;

  assign endCmd   = csRise && (bitCnt == CNT_W'(CMD_BITS));
  assign endWrite = csRise && (bitCnt == CNT_W'(FRAME_BITS));
  assign anyCmd   = csRise && (bitCnt >= CNT_W'(CMD_BITS));
  assign opcode   = endCmd ? shiftWord[CMD_BITS-1:0]
                           : shiftWord[FRAME_BITS-1:DATA_BITS];

  assign doWren  = endCmd   && (opcode == CMD_BITS'(OP_WRITE_EN));
  assign doArm   = endCmd   && (opcode == CMD_BITS'(OP_RESET_ARM));
  assign doReset = endCmd   && (opcode == CMD_BITS'(OP_RESET_GO)) && rstArmed;
  assign doLoad  = endWrite && (opcode == CMD_BITS'(OP_WRITE_CFG)) && wel;

  assign strobe = '{loadCfg: doLoad, restoreCfg: doReset};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel      <= 1'b0;
      rstArmed <= 1'b0;
      softRst  <= 1'b0;
    end else begin
      softRst <= doReset;
      if (doReset || doLoad) wel <= 1'b0;
      else if (doWren)       wel <= 1'b1;
      if (anyCmd) rstArmed <= doArm;
    end
  end

  // R7: reset pulse lasts a single cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !softRst);

  // R8: a reset pulse needs an armed sequence
  a_r8_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRst) |-> $past(rstArmed));

  // R2: latch only rises at the end of an exact one-byte frame
  a_r2_wel_rise_at_cmd_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(csRise && (bitCnt == CNT_W'(CMD_BITS))));

endmodule

// File: rtl/flash_reg_cmd.sv
module flash_reg_cmd
  import flash_reg_cmd_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int DATA_BITS = 8,
  localparam int FRAME_BITS = CMD_BITS + DATA_BITS,
  localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sclk,
  input  logic                 mosi,
  input  logic [DATA_BITS-1:0] nvCfg,
  output logic [DATA_BITS-1:0] cfgReg,
  output logic                 wel,
  output logic                 softRst
);

  dpStrobe_t             strobe;
  logic                  csRise;
  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] shiftWord;

  cfg_datapath #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS)) uDatapath (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .nvCfg(nvCfg), .strobe(strobe), .csRise(csRise), .bitCnt(bitCnt),
    .shiftWord(shiftWord), .cfgReg(cfgReg)
  );

  cmd_sequencer #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS)) uSequencer (
    .clk(clk), .rstN(rstN), .csRise(csRise), .bitCnt(bitCnt),
    .shiftWord(shiftWord), .strobe(strobe), .wel(wel), .softRst(softRst)
  );

  // R4/R11: the register moves only through a latched write or a reset
  a_r4_cfg_guarded: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg != $past(cfgReg)) |-> ($past(wel) || softRst));

  // R7: a reset pulse leaves the latch cleared
  a_r7_reset_clears_wel: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> !wel);

endmodule

// File: tb/tb_flash_reg_cmd.sv
module tb_flash_reg_cmd;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic [7:0] nvCfg = 8'hA5;
  logic [7:0] cfgReg;
  logic       wel;
  logic       softRst;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [7:0] expCfg = 8'hA5;
  logic       expWel = 1'b0;
  logic       expRst = 1'b0;
  bit         armed = 1'b0;

  always #2.5 clk = ~clk;

  flash_reg_cmd dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .nvCfg(nvCfg), .cfgReg(cfgReg), .wel(wel), .softRst(softRst)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edges
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN) begin
        check({curReq, " cfgReg"}, cfgReg, expCfg);
        check({curReq, " wel"}, {7'd0, wel}, {7'd0, expWel});
        check({curReq, " softRst"}, {7'd0, softRst}, {7'd0, expRst});
      end
    end
  end

  task automatic model(input logic [31:0] w, input int n);
    if (n == 8) begin
      case (w[7:0])
        8'h06: begin expWel = 1'b1; armed = 1'b0; end
        8'h66: armed = 1'b1;
        8'h99: begin
          if (armed) begin expRst = 1'b1; expCfg = nvCfg; expWel = 1'b0; end
          armed = 1'b0;
        end
        default: armed = 1'b0;
      endcase
    end else if (n == 16 && w[15:8] == 8'h61) begin
      if (expWel) begin expCfg = w[7:0]; expWel = 1'b0; end
      armed = 1'b0;
    end else if (n >= 8) begin
      armed = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] w, input int n);
    @(negedge clk); csN = 1'b0;
    @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = w[i];
      @(negedge clk); sclk = 1'b1;
      @(negedge clk);
      @(negedge clk); sclk = 1'b0;
      @(negedge clk);
    end
    csN = 1'b1;
    model(w, n);
    @(negedge clk); expRst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #0.5;
    check("R1 cfgReg in reset", cfgReg, 8'hA5);
    check("R1 wel in reset", {7'd0, wel}, 8'd0);
    check("R1 softRst in reset", {7'd0, softRst}, 8'd0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);

    curReq = "R6";
    frame(32'h03, 7);
    frame(32'h0C, 9);
    check("R6 wel after short/long frames", {7'd0, wel}, 8'd0);

    curReq = "R4";
    frame(32'h615A, 16);
    check("R4 cfg unchanged with latch clear", cfgReg, 8'hA5);

    curReq = "R2";
    frame(32'h06, 8);
    check("R2 wel set", {7'd0, wel}, 8'd1);

    curReq = "R5";
    frame(32'h30AD, 15);
    frame(32'hC2B5, 17);
    check("R5 cfg unchanged", cfgReg, 8'hA5);
    check("R5 wel kept", {7'd0, wel}, 8'd1);

    curReq = "R3";
    frame(32'h615A, 16);
    check("R3 cfg loaded", cfgReg, 8'h5A);
    check("R3 wel cleared", {7'd0, wel}, 8'd0);
    frame(32'h06, 8);
    frame(32'h61C3, 16);
    check("R3 second load", cfgReg, 8'hC3);

    curReq = "R10";
    repeat (3) begin
      @(negedge clk); sclk = 1'b1; mosi = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    frame(32'h06, 8);
    check("R10 idle clocks ignored", {7'd0, wel}, 8'd1);

    curReq = "R9";
    frame(32'h00, 8);
    frame(32'hFF12, 16);
    check("R9 cfg unchanged", cfgReg, 8'hC3);
    check("R9 wel kept", {7'd0, wel}, 8'd1);

    curReq = "R11";
    @(negedge clk); nvCfg = 8'h3C;
    repeat (4) @(negedge clk);
    check("R11 nvCfg change ignored", cfgReg, 8'hC3);

    curReq = "R8";
    frame(32'h99, 8);
    frame(32'h66, 8);
    frame(32'h06, 8);
    frame(32'h99, 8);
    check("R8 unarmed reset ignored", cfgReg, 8'hC3);

    curReq = "R7";
    frame(32'h66, 8);
    frame(32'h05, 3);
    frame(32'h99, 8);
    check("R7 cfg restored", cfgReg, 8'h3C);
    check("R7 wel cleared", {7'd0, wel}, 8'd0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule